// File: doc/BRIEF.md
# Index-Prefix Opcode Decoder

This block is the first stage of an 8-bit processor's instruction decoder. It takes fetched opcode bytes one at a time over a valid/ready handshake. It recognises the two index-prefix bytes and records which index register, X or Y, should replace the HL pair in the instruction that follows. For each non-prefix byte it produces one registered descriptor. The descriptor gives the index selection and the prefix cost in clock states. It also says whether the instruction reads memory through HL, whether a signed displacement byte must be fetched next, whether HL is replaced as a 16-bit value, whether an 8-bit H or L operand maps onto a half of the index register, and whether the opcode is the register-indirect jump.

Prefix bytes produce no descriptor of their own. Each one is a 4-state no-op that sets the substitution mode again, and the last prefix before an ordinary opcode decides the mode. The mode clears once that opcode is accepted. Only the rows of the main opcode table that involve HL, H or L are classified here. Every other opcode passes through with all substitution flags low.

Top module: `ixp_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, no substitution mode is pending, and the first descriptor after reset has `out_sel` = 0 unless a prefix came before it.
- R2: `in_ready` equals `!out_valid || out_ready`. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. An accepted non-prefix byte produces a descriptor with `out_valid` = 1 and `out_opcode` equal to that byte, starting the next cycle. The descriptor stays unchanged until it is taken with `out_ready` = 1. An accepted prefix byte produces no descriptor.
- R3: `out_sel` encodes the substitution: 0 means HL, 1 means X (set by byte 0xDD), and 2 means Y (set by byte 0xFD). It applies only to the next non-prefix byte and is cleared once that byte is accepted.
- R4: In a run that mixes both prefix bytes, the last one before the non-prefix byte decides `out_sel`.
- R5: `out_pfx_states` is 4 times the number of prefix bytes accepted since the previous non-prefix byte. The count saturates at 2^CNT_W-1, so the default maximum is 60 states.
- R6: `out_mem` is 1 for the memory-through-HL forms. These are 0x34, 0x35 and 0x36. In 0x40–0x7F they are the opcodes with bits[2:0]=6 or bits[5:3]=6, leaving out 0x76. In 0x80–0xBF they are the opcodes with bits[2:0]=6. `out_disp` equals `out_mem` with `out_sel` ≠ 0.
- R7: `out_wide` is 1 when `out_sel` ≠ 0 and the opcode uses HL as a 16-bit value. These opcodes are 0x09, 0x19, 0x29, 0x39, 0x21, 0x22, 0x2A, 0x23, 0x2B, 0xE1, 0xE5, 0xE3, 0xF9 and 0xE9.
- R8: `out_half` is 1 when `out_sel` ≠ 0, the opcode is not a memory form from R6, and it names H or L as an 8-bit register. These opcodes are 0x24–0x26 and 0x2C–0x2E. In 0x40–0x7F they are the opcodes with a register field (bits[5:3] or bits[2:0]) equal to 4 or 5. In 0x80–0xBF they are the opcodes with bits[2:0] equal to 4 or 5.
- R9: For opcode 0xE9, `out_jump` is 1, `out_mem` and `out_disp` are 0, and `out_wide` is 1 exactly when a prefix is in effect. The jump target is the index register itself.
- R10: All other opcodes, including 0x76 and 0xEB, leave `out_mem`, `out_disp`, `out_wide`, `out_half` and `out_jump` at 0, whether or not a prefix came before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched byte present |
| in_ready | output | 1 | Decoder can accept a byte |
| in_byte | input | 8 | Fetched opcode byte |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_opcode | output | 8 | Opcode the descriptor belongs to |
| out_sel | output | 2 | 0 HL, 1 index X, 2 index Y |
| out_mem | output | 1 | Memory access through HL form |
| out_disp | output | 1 | Displacement byte must follow |
| out_wide | output | 1 | 16-bit HL replaced by index register |
| out_half | output | 1 | H/L operand maps to index half |
| out_jump | output | 1 | Register-indirect jump opcode |
| out_pfx_states | output | CNT_W+2 | Clock states spent on prefixes |

## Verification
The assertions assume that the consumer never takes a descriptor it has not been offered, and that reset is held for at least one clock edge before any byte is presented. They also assume that `in_byte` is a defined value whenever `in_valid` is high. The stimulus drives bytes and the ready signal only at the falling edge and keeps every input at a known value. It mixes long prefix runs and alternating prefix kinds with random opcodes, and stalls the consumer at random so that descriptors are held across cycles.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

  typedef enum logic [1:0] {
    SEL_HL = 2'd0,
    SEL_X  = 2'd1,
    SEL_Y  = 2'd2
  } idx_sel_e;

  typedef struct packed {
    logic [7:0] opcode;
    idx_sel_e   sel;
    logic       mem;
    logic       disp;
    logic       wide;
    logic       half;
    logic       jump;
  } desc_t;

  localparam logic [7:0] OP_JUMP_REG = 8'hE9;
  localparam logic [7:0] OP_HALT     = 8'h76;

  // memory operand addressed through the HL pair
  function automatic logic f_mem_form(input logic [7:0] op);
    logic r;
    r = 1'b0;
    if (op == 8'h34 || op == 8'h35 || op == 8'h36) r = 1'b1;
    else if (op[7:6] == 2'b01 && op != OP_HALT)
      r = (op[2:0] == 3'd6) || (op[5:3] == 3'd6);
    else if (op[7:6] == 2'b10)
      r = (op[2:0] == 3'd6);
    return r;
  endfunction

  // HL used as a 16-bit quantity, no memory indirection
  function automatic logic f_wide_form(input logic [7:0] op);
    case (op)
      8'h09, 8'h19, 8'h29, 8'h39,
      8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B,
      8'hE1, 8'hE5, 8'hE3, 8'hF9, OP_JUMP_REG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // H or L named as an 8-bit register operand (field code 4 or 5)
  function automatic logic f_names_hl8(input logic [7:0] op);
    logic r;
    r = 1'b0;
    if (op == 8'h24 || op == 8'h25 || op == 8'h26 ||
        op == 8'h2C || op == 8'h2D || op == 8'h2E) r = 1'b1;
    else if (op[7:6] == 2'b01 && op != OP_HALT)
      r = (op[2:1] == 2'b10) || (op[5:4] == 2'b10);
    else if (op[7:6] == 2'b10)
      r = (op[2:1] == 2'b10);
    return r;
  endfunction

endpackage

// File: rtl/ixp_mode_track.sv
module ixp_mode_track
  import ixp_pkg::*;
#(
  parameter int         CNT_W = 4,
  parameter logic [7:0] PFX_X = 8'hDD,
  parameter logic [7:0] PFX_Y = 8'hFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_i,
  input  logic             acc_pfx,
  input  logic             acc_op,
  output logic             is_prefix,
  output idx_sel_e         mode_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic is_y;

  assign is_y      = (byte_i == PFX_Y);
  assign is_prefix = (byte_i == PFX_X) || is_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SEL_HL;
      cnt_q  <= '0;
    end else if (acc_op) begin
      mode_q <= SEL_HL;
      cnt_q  <= '0;
    end else if (acc_pfx) begin
      mode_q <= is_y ? SEL_Y : SEL_X;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ixp_classify.sv
module ixp_classify
  import ixp_pkg::*;
(
  input  logic [7:0] opcode,
  input  idx_sel_e   sel,
  output desc_t      desc
);
  logic subst, mem, hl8;

  assign subst = (sel != SEL_HL);
  assign mem   = f_mem_form(opcode);
  assign hl8   = f_names_hl8(opcode);

  always_comb begin
    desc.opcode = opcode;
    desc.sel    = sel;
    desc.mem    = mem;
    desc.disp   = mem && subst;
    desc.wide   = subst && f_wide_form(opcode);
    desc.half   = subst && hl8 && !mem;
    desc.jump   = (opcode == OP_JUMP_REG);
  end
endmodule

// File: rtl/ixp_desc_reg.sv
module ixp_desc_reg
  import ixp_pkg::*;
#(
  parameter int ST_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            take,
  input  desc_t           d_desc,
  input  logic [ST_W-1:0] d_states,
  output logic            valid_q,
  output desc_t           q_desc,
  output logic [ST_W-1:0] q_states
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      q_desc   <= '0;
      q_states <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      q_desc   <= d_desc;
      q_states <= d_states;
    end else if (take) begin
      valid_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ixp_decoder.sv
module ixp_decoder
  import ixp_pkg::*;
#(
  parameter int         CNT_W = 4,
  parameter logic [7:0] PFX_X = 8'hDD,
  parameter logic [7:0] PFX_Y = 8'hFD,
  localparam int        ST_W  = CNT_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_byte,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_opcode,
  output logic [1:0]      out_sel,
  output logic            out_mem,
  output logic            out_disp,
  output logic            out_wide,
  output logic            out_half,
  output logic            out_jump,
  output logic [ST_W-1:0] out_pfx_states
);
  logic             is_prefix, acc, acc_pfx, acc_op;
  idx_sel_e         mode_q;
  logic [CNT_W-1:0] cnt_q;
  desc_t            cls_desc, q_desc;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign acc_pfx  = acc && is_prefix;
  assign acc_op   = acc && !is_prefix;

  ixp_mode_track #(.CNT_W(CNT_W), .PFX_X(PFX_X), .PFX_Y(PFX_Y)) u_track (
    .clk(clk), .rst_n(rst_n), .byte_i(in_byte),
    .acc_pfx(acc_pfx), .acc_op(acc_op),
    .is_prefix(is_prefix), .mode_q(mode_q), .cnt_q(cnt_q)
  );

  ixp_classify u_cls (
    .opcode(in_byte), .sel(mode_q), .desc(cls_desc)
  );

  ixp_desc_reg #(.ST_W(ST_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(acc_op), .take(out_ready),
    .d_desc(cls_desc), .d_states({cnt_q, 2'b00}),
    .valid_q(out_valid), .q_desc(q_desc), .q_states(out_pfx_states)
  );

  assign out_opcode = q_desc.opcode;
  assign out_sel    = q_desc.sel;
  assign out_mem    = q_desc.mem;
  assign out_disp   = q_desc.disp;
  assign out_wide   = q_desc.wide;
  assign out_half   = q_desc.half;
  assign out_jump   = q_desc.jump;
endmodule

// File: rtl/ixp_decoder_chk.sv
module ixp_decoder_chk #(
  parameter logic [7:0] PFX_Y = 8'hFD
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_opcode,
  input logic [1:0] out_sel,
  input logic       out_mem,
  input logic       out_disp,
  input logic       out_wide,
  input logic       out_half,
  input logic       out_jump,
  input logic [1:0] mode,
  input logic       acc_pfx,
  input logic       acc_op
);
  AST_PFX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pfx && !out_valid |=> !out_valid); // R2
  AST_HOLD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_sel)
      && $stable(out_mem) && $stable(out_half) && $stable(out_wide)); // R2
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_op |=> mode == 2'd0); // R3
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sel != 2'd3); // R3
  AST_LAST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pfx && in_byte == PFX_Y |=> mode == 2'd2); // R4
  AST_DISP_NEEDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_disp |-> out_mem && out_sel != 2'd0); // R6
  AST_HALF_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_half |-> !out_mem && out_sel != 2'd0); // R8
  AST_JUMP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_jump |-> !out_mem && !out_disp && (out_wide == (out_sel != 2'd0))); // R9
endmodule

bind ixp_decoder ixp_decoder_chk #(.PFX_Y(PFX_Y)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte),
  .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
  .out_sel(out_sel), .out_mem(out_mem), .out_disp(out_disp),
  .out_wide(out_wide), .out_half(out_half), .out_jump(out_jump),
  .mode(mode_q), .acc_pfx(acc_pfx), .acc_op(acc_op)
);

// File: tb/tb_ixp_decoder.sv
`timescale 1ns/1ps
module tb_ixp_decoder;
  localparam int CNT_W = 4;
  localparam int ST_W  = CNT_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_mem, out_disp, out_wide, out_half, out_jump;
  logic [7:0] out_opcode;
  logic [1:0] out_sel;
  logic [ST_W-1:0] out_pfx_states;

  always #2.5 clk = ~clk;

  ixp_decoder #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_sel(out_sel), .out_mem(out_mem),
    .out_disp(out_disp), .out_wide(out_wide), .out_half(out_half),
    .out_jump(out_jump), .out_pfx_states(out_pfx_states)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // model state
  int  m_sel = 0, m_cnt = 0;
  bit  pend = 0;
  int  e_op, e_sel, e_st;
  bit  e_mem, e_disp, e_wide, e_half, e_jump;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit x_mem(input int op);
    int hi = (op >> 3) & 7, lo = op & 7;
    if (op >= 'h34 && op <= 'h36) return 1;
    if (op >= 'h40 && op < 'h80 && op != 'h76) return (lo == 6) || (hi == 6);
    if (op >= 'h80 && op < 'hC0) return lo == 6;
    return 0;
  endfunction

  function automatic bit x_wide(input int op);
    int rows[14] = '{'h09,'h19,'h29,'h39,'h21,'h22,'h2A,'h23,'h2B,'hE1,'hE5,'hE3,'hF9,'hE9};
    foreach (rows[i]) if (rows[i] == op) return 1;
    return 0;
  endfunction

  function automatic bit x_hl8(input int op);
    int hi = (op >> 3) & 7, lo = op & 7;
    if ((op >= 'h24 && op <= 'h26) || (op >= 'h2C && op <= 'h2E)) return 1;
    if (op >= 'h40 && op < 'h80 && op != 'h76) return (lo == 4 || lo == 5 || hi == 4 || hi == 5);
    if (op >= 'h80 && op < 'hC0) return (lo == 4 || lo == 5);
    return 0;
  endfunction

  task automatic compare();
    string ft;
    ft = (!e_mem && !e_wide && !e_half && !e_jump) ? "R10" : "";
    chk(out_opcode == e_op[7:0], "R2 opcode", out_opcode, e_op);
    chk(out_sel == e_sel[1:0], "R3/R4 sel", out_sel, e_sel);
    chk(out_pfx_states == e_st[ST_W-1:0], "R5 states", out_pfx_states, e_st);
    chk(out_mem == e_mem, {"R6 mem ", ft}, out_mem, e_mem);
    chk(out_disp == e_disp, {"R6 disp ", ft}, out_disp, e_disp);
    chk(out_wide == e_wide, {"R7 wide ", ft}, out_wide, e_wide);
    chk(out_half == e_half, {"R8 half ", ft}, out_half, e_half);
    chk(out_jump == e_jump, {"R9 jump ", ft}, out_jump, e_jump);
  endtask

  task automatic step(input bit v, input int b, input bit r);
    bit acc;
    @(negedge clk);
    in_valid = v; in_byte = b[7:0]; out_ready = r;
    #1;
    chk(in_ready == (!out_valid || r), "R2 in_ready", in_ready, !out_valid || r);
    chk(out_valid == pend, "R2 out_valid", out_valid, pend);
    if (out_valid && pend) compare();
    acc = v && in_ready;
    if (out_valid && r) pend = 0;
    if (acc) begin
      if (b == 'hDD || b == 'hFD) begin
        m_sel = (b == 'hFD) ? 2 : 1;
        if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
      end else begin
        pend   = 1;
        e_op   = b;
        e_sel  = m_sel;
        e_st   = 4 * m_cnt;
        e_mem  = x_mem(b);
        e_disp = e_mem && (m_sel != 0);
        e_wide = (m_sel != 0) && x_wide(b);
        e_half = (m_sel != 0) && x_hl8(b) && !e_mem;
        e_jump = (b == 'hE9);
        m_sel = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic seq(input int b);
    step(1, b, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    // R1: first instruction after reset is unprefixed
    seq('h66);
    // R6: indexed memory form, H not remapped
    seq('hDD); seq('h66);
    // R8: index half load
    seq('hFD); seq('h26);
    // R4: last prefix wins, R7 wide
    seq('hDD); seq('hFD); seq('h21);
    seq('hFD); seq('hDD); seq('hE9);  // R9
    seq('hDD); seq('hEB);             // R10
    seq('hDD); seq('h00);             // R10
    seq('hFD); seq('h76);             // R10
    for (int i = 0; i < 20; i++) seq((i % 3 == 0) ? 'hFD : 'hDD);
    seq('h7E);                        // R5 saturation
    seq('hFD); seq('h74);             // R6 mem, no half
    seq('hDD); seq('h84);             // R8
    seq('hDD); seq('h09);             // R7
    seq('h44);                        // R3 flag cleared
    seq('hE9);                        // R9 without prefix
    // stalled consumer, R2 hold
    seq('hDD); step(1, 'h36, 0); step(1, 'h12, 0); step(1, 'h12, 0); step(0, 0, 1);
    for (int i = 0; i < 4000; i++) begin
      int b;
      int k = $urandom % 8;
      b = (k == 0) ? 'hDD : (k == 1) ? 'hFD : ($urandom % 256);
      step(($urandom % 10) < 8, b, ($urandom % 10) < 7);
    end
    repeat (3) step(0, 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule